// File: doc/BRIEF.md
# Idle-Pair Rate Match FIFO

This block is an elastic buffer that sits between a recovered receive clock and the local system clock on a gigabit Ethernet physical coding sublayer receive path. Code groups arrive already decoded. Each one is an 8-bit byte plus a control flag (K). They are written on `wr_clk` and read out on `rd_clk`. The two clocks are nominally equal but drift apart, so the buffer keeps its fill near the middle of a 16-entry store. It does this by dropping or repeating whole two-symbol idle sets of the disparity-preserving kind: a K28.5 comma (byte 0xBC, K=1) followed directly by D16.2 (byte 0x50, K=0). It never touches any other symbols.

The write side runs a three-state machine:

- `W_EMPTY`: nothing is held.
- `W_HOLD`: an ordinary symbol is held.
- `W_COMMA`: a K28.5 is held.

Every accepted symbol is held for one input beat before it is committed to the store. When a D16.2 arrives in `W_COMMA` and the write-side fill is above 12, neither symbol is written. The machine goes to `W_EMPTY` and `del_flag` pulses. Otherwise the held symbol is committed, and the new symbol moves the machine to `W_COMMA` (if it is a K28.5) or to `W_HOLD` (anything else).

The read side runs a four-state machine:

- `R_NORM`: plain reading.
- `R_SAWK`: the last symbol read was a K28.5.
- `R_INS_K` and `R_INS_D`: replay of an idle pair.

When a D16.2 is read in `R_SAWK` while the read-side fill is below 4, the machine goes through `R_INS_K` and then `R_INS_D`. In those two states it emits the pair again without moving the read pointer, and `ins_flag` is raised. It then returns to `R_NORM`. Any other symbol read in `R_SAWK` goes back to `R_NORM`, except another K28.5, which stays in `R_SAWK`. A K28.5 read in `R_NORM` moves the machine to `R_SAWK`.

Both pointers cross between the clock domains in Gray code through two-flop synchronizers.

Top module: `idle_rate_fifo`

## Requirements
- R1: Apart from deleted and inserted idle pairs, the read side delivers exactly the accepted input symbols, in order, with data and K unchanged. Both pointers cross domains in Gray code and change by at most one bit per clock.
- R2: Only K28.5 (0xBC with K=1) immediately followed by D16.2 (0x50 with K=0) counts as an idle pair. The byte 0xBC with K=0, the byte 0x50 with K=1, and a K28.5 and D16.2 with another symbol between them are never deleted and never repeated.
- R3: A pair is deleted only when its D16.2 is accepted while the write-side fill exceeds 12. Neither of its two symbols then reaches the store. At low fill no pair is deleted.
- R4: `del_flag` is high for exactly two `wr_clk` cycles per deletion. It goes high in the cycle after the edge that accepts the D16.2.
- R5: A pair is repeated only when its D16.2 is read while the read-side fill is below 4. At high fill no repetition occurs.
- R6: A repeated pair appears as K28.5 and then D16.2 on the two output cycles right after the original D16.2. `ins_flag` is high on exactly those two cycles.
- R7: A repeat never splits a set. The two outputs before `ins_flag` rises are a complete K28.5 and D16.2 pair.
- R8: After reset `out_valid`, `del_flag` and `ins_flag` are low.
- R9: While nothing is readable, `out_valid` stays low.
- R10: An accepted symbol is committed to the store only when the next symbol is accepted, so the last accepted symbol does not appear at the output until another one follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Recovered receive clock (write side) |
| wr_rst_n | input | 1 | Asynchronous active-low reset, write side |
| in_valid | input | 1 | A symbol is present on `in_data`/`in_k` |
| in_data | input | 8 | Decoded symbol byte |
| in_k | input | 1 | Control flag of the symbol |
| del_flag | output | 1 | Two-cycle pulse per deleted idle pair (`wr_clk`) |
| rd_clk | input | 1 | Local system clock (read side) |
| rd_rst_n | input | 1 | Asynchronous active-low reset, read side |
| out_valid | output | 1 | A symbol is present on `out_data`/`out_k` |
| out_data | output | 8 | Output symbol byte |
| out_k | output | 1 | Control flag of the output symbol |
| ins_flag | output | 1 | High on the two cycles of a repeated idle pair (`rd_clk`) |

## Verification
A random stream, mostly idle pairs with short runs of plain data and the odd stray 0xBC data byte mixed in, is sent in two phases. In the first phase the write clock is faster than the read clock, which must force deletions and no repeats once the buffer has filled. In the second phase the write clock is slower, which must force repeats. Every output is matched against a bench queue, so a deletion or repeat of the wrong symbols shows up as a data mismatch rather than only as a wrong flag count. Directed short sequences separate true idle pairs from look-alikes: a wrong K flag, or a symbol between the comma and the D16.2. They also show the one-symbol hold on the write side and the empty behaviour at low fill.

// File: rtl/rmf_pkg.sv
package rmf_pkg;

    localparam logic [7:0] COMMA_BYTE = 8'hBC;
    localparam logic [7:0] IDLE2_BYTE = 8'h50;

    typedef struct packed {
        logic       k;
        logic [7:0] data;
    } sym_t;

    typedef enum logic [1:0] {
        W_EMPTY,
        W_HOLD,
        W_COMMA
    } wr_state_t;

    typedef enum logic [1:0] {
        R_NORM,
        R_SAWK,
        R_INS_K,
        R_INS_D
    } rd_state_t;

    function automatic logic is_comma(input sym_t s);
        return s.k && (s.data == COMMA_BYTE);
    endfunction

    function automatic logic is_idle2(input sym_t s);
        return !s.k && (s.data == IDLE2_BYTE);
    endfunction

endpackage

// File: rtl/rmf_gray_sync.sv
module rmf_gray_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
        logic [W-1:0] b;
        b[W-1] = g[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= gray_in;
            sync_q <= meta_q;
        end
    end

    assign bin_out = gray_to_bin(sync_q);

endmodule

// File: rtl/rmf_wr_ctrl.sv
module rmf_wr_ctrl
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  sym_t          in_sym,
    input  logic [PW-1:0] rptr_bin,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output sym_t          wr_sym,
    output logic [PW-1:0] wptr_gray,
    output logic          del_flag
);

    localparam logic [PW-1:0] HI_V = PW'(HI_MARK);

    wr_state_t     state, state_nx;
    sym_t          hold_q;
    logic [PW-1:0] wptr, wptr_nx, wfill;
    logic          pair_seen, del_ev;
    logic          pulse_a, pulse_b;

    assign wfill     = wptr - rptr_bin;
    assign pair_seen = (state == W_COMMA) && in_valid && is_idle2(in_sym);
    assign del_ev    = pair_seen && (wfill > HI_V);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            W_EMPTY, W_HOLD: begin
                if (in_valid) state_nx = is_comma(in_sym) ? W_COMMA : W_HOLD;
            end
            W_COMMA: begin
                if (in_valid) begin
                    if (del_ev)                state_nx = W_EMPTY;
                    else if (is_comma(in_sym)) state_nx = W_COMMA;
                    else                       state_nx = W_HOLD;
                end
            end
            default: state_nx = W_EMPTY;
        endcase
    end

    // outputs toward the store
    always_comb begin
        wr_en   = in_valid && (state != W_EMPTY) && !del_ev;
        wr_sym  = hold_q;
        wr_addr = wptr[AW-1:0];
        wptr_nx = wptr + PW'(wr_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= W_EMPTY;
            hold_q    <= '0;
            wptr      <= '0;
            wptr_gray <= '0;
            pulse_a   <= 1'b0;
            pulse_b   <= 1'b0;
        end else begin
            state     <= state_nx;
            if (in_valid) hold_q <= in_sym;
            wptr      <= wptr_nx;
            wptr_gray <= wptr_nx ^ (wptr_nx >> 1);
            pulse_a   <= del_ev;
            pulse_b   <= pulse_a;
        end
    end

    assign del_flag = pulse_a | pulse_b;

    p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wptr_gray ^ $past(wptr_gray)));

    p_del_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(del_flag) |=> del_flag);

    p_del_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(del_flag) |-> $past(del_flag, 2));

    p_del_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(del_flag) |-> $past(in_valid && !in_sym.k && (in_sym.data == IDLE2_BYTE) && !wr_en));

endmodule

// File: rtl/rmf_rd_ctrl.sv
module rmf_rd_ctrl
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int LO_MARK = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] wptr_bin,
    output logic [AW-1:0] rd_addr,
    input  sym_t          rd_sym,
    output logic [PW-1:0] rptr_gray,
    output logic          out_valid,
    output logic [7:0]    out_data,
    output logic          out_k,
    output logic          ins_flag
);

    localparam logic [PW-1:0] LO_V = PW'(LO_MARK);

    rd_state_t     state, state_nx;
    logic [PW-1:0] rptr, rptr_nx, rfill;
    logic          have, rd_take, ins_ev;

    assign rfill   = wptr_bin - rptr;
    assign have    = (rfill != '0);
    assign rd_take = have && ((state == R_NORM) || (state == R_SAWK));
    assign ins_ev  = (state == R_SAWK) && rd_take && is_idle2(rd_sym) && (rfill < LO_V);
    assign rd_addr = rptr[AW-1:0];
    assign rptr_nx = rptr + PW'(rd_take);

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            R_NORM: begin
                if (rd_take && is_comma(rd_sym)) state_nx = R_SAWK;
            end
            R_SAWK: begin
                if (rd_take) begin
                    if (ins_ev)                state_nx = R_INS_K;
                    else if (is_comma(rd_sym)) state_nx = R_SAWK;
                    else                       state_nx = R_NORM;
                end
            end
            R_INS_K: state_nx = R_INS_D;
            R_INS_D: state_nx = R_NORM;
            default: state_nx = R_NORM;
        endcase
    end

    // state register and pointer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= R_NORM;
            rptr      <= '0;
            rptr_gray <= '0;
        end else begin
            state     <= state_nx;
            rptr      <= rptr_nx;
            rptr_gray <= rptr_nx ^ (rptr_nx >> 1);
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_k     <= 1'b0;
            ins_flag  <= 1'b0;
        end else begin
            unique case (state)
                R_INS_K: begin
                    out_valid <= 1'b1;
                    out_data  <= COMMA_BYTE;
                    out_k     <= 1'b1;
                    ins_flag  <= 1'b1;
                end
                R_INS_D: begin
                    out_valid <= 1'b1;
                    out_data  <= IDLE2_BYTE;
                    out_k     <= 1'b0;
                    ins_flag  <= 1'b1;
                end
                default: begin
                    out_valid <= rd_take;
                    ins_flag  <= 1'b0;
                    if (rd_take) begin
                        out_data <= rd_sym.data;
                        out_k    <= rd_sym.k;
                    end
                end
            endcase
        end
    end

    p_gray_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rptr_gray ^ $past(rptr_gray)));

    p_ins_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_flag) |-> out_valid && out_k && (out_data == COMMA_BYTE));

    p_ins_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_flag) |=> ins_flag && out_valid && !out_k && (out_data == IDLE2_BYTE));

    p_ins_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_flag) |-> ##2 !ins_flag);

    p_ins_after_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ins_flag) |-> $past(out_valid) && !$past(out_k) && ($past(out_data) == IDLE2_BYTE));

endmodule

// File: rtl/idle_rate_fifo.sv
module idle_rate_fifo
    import rmf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 12,
    parameter int LO_MARK = 4
) (
    input  logic       wr_clk,
    input  logic       wr_rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_k,
    output logic       del_flag,
    input  logic       rd_clk,
    input  logic       rd_rst_n,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_k,
    output logic       ins_flag
);

    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    sym_t          store [DEPTH];
    sym_t          in_sym, wr_sym, rd_sym;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [PW-1:0] wptr_gray, rptr_gray, wptr_rd, rptr_wr;

    assign in_sym = {in_k, in_data};

    rmf_wr_ctrl #(.DEPTH(DEPTH), .HI_MARK(HI_MARK)) u_wr (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .in_valid  (in_valid),
        .in_sym    (in_sym),
        .rptr_bin  (rptr_wr),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_sym    (wr_sym),
        .wptr_gray (wptr_gray),
        .del_flag  (del_flag)
    );

    always_ff @(posedge wr_clk) begin
        if (wr_en) store[wr_addr] <= wr_sym;
    end

    assign rd_sym = store[rd_addr];

    rmf_gray_sync #(.W(PW)) u_w2r (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .gray_in (wptr_gray),
        .bin_out (wptr_rd)
    );

    rmf_gray_sync #(.W(PW)) u_r2w (
        .clk     (wr_clk),
        .rst_n   (wr_rst_n),
        .gray_in (rptr_gray),
        .bin_out (rptr_wr)
    );

    rmf_rd_ctrl #(.DEPTH(DEPTH), .LO_MARK(LO_MARK)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .wptr_bin  (wptr_rd),
        .rd_addr   (rd_addr),
        .rd_sym    (rd_sym),
        .rptr_gray (rptr_gray),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_k     (out_k),
        .ins_flag  (ins_flag)
    );

endmodule

// File: tb/idle_rate_fifo_bench.sv
module idle_rate_fifo_bench;

    localparam int CLK_PERIOD  = 10;  // read clock
    localparam int WR_FAST     = 8;
    localparam int WR_SLOW     = 12;
    localparam int WATCHDOG    = 150000;
    localparam logic [8:0] KCOMMA = 9'h1BC;
    localparam logic [8:0] DIDLE  = 9'h050;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_rst_n = 1'b0, rd_rst_n = 1'b0;
    logic       in_valid = 1'b0, in_k = 1'b0;
    logic [7:0] in_data = '0;
    logic       del_flag, out_valid, out_k, ins_flag;
    logic [7:0] out_data;
    int         wr_half = WR_FAST / 2;

    idle_rate_fifo u_idle_rate_fifo (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_k(in_k), .del_flag(del_flag), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
        .out_valid(out_valid), .out_data(out_data), .out_k(out_k), .ins_flag(ins_flag)
    );

    always #(CLK_PERIOD / 2) rd_clk = ~rd_clk;
    always begin #(wr_half); wr_clk = ~wr_clk; end

    int total = 0, bad = 0;
    logic [8:0] exp_q[$];
    logic [8:0] w0, w1, o0, o1;
    int  nvw = 0, nout = 0, n_del = 0, n_ins = 0, rd_cycles = 0;
    bit  last_drive_valid = 0, ev_prev = 0, ins_phase = 0, done = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_pair(input logic [8:0] a, input logic [8:0] b);
        return (a == KCOMMA) && (b == DIDLE);
    endfunction

    function automatic logic [8:0] ins_expect(input bit phase);
        return phase ? DIDLE : KCOMMA;
    endfunction

    // write-side observation of del_flag, done just before the next drive
    task automatic observe_del();
        bit pair_done;
        pair_done = last_drive_valid && (nvw >= 2) && is_pair(w1, w0);
        if (del_flag) begin
            if (pair_done) begin
                logic [8:0] b0, b1;
                chk(exp_q.size() >= 8, "R3", "fill at deletion", exp_q.size(), 8);
                b0 = exp_q.pop_back();
                b1 = exp_q.pop_back();
                chk(is_pair(b1, b0), "R3", "deleted symbols", {b1, b0}, {KCOMMA, DIDLE});
                n_del++;
                ev_prev = 1;
            end else begin
                chk(ev_prev, "R4", "del_flag high without pair", 1, 0);
                ev_prev = 0;
            end
        end else begin
            chk(!ev_prev, "R4", "del_flag second cycle", 0, 1);
            ev_prev = 0;
        end
    endtask

    task automatic send(input bit v, input bit k, input logic [7:0] d);
        @(negedge wr_clk);
        observe_del();
        in_valid = v; in_k = k; in_data = d;
        if (v) begin
            exp_q.push_back({k, d});
            w1 = w0; w0 = {k, d}; nvw++;
        end
        last_drive_valid = v;
    endtask

    task automatic idle_wr(input int n);
        for (int i = 0; i < n; i++) send(1'b0, 1'b0, 8'h00);
    endtask

    task automatic do_reset();
        wr_rst_n = 1'b0; rd_rst_n = 1'b0;
        in_valid = 1'b0;
        repeat (4) @(negedge rd_clk);
        exp_q.delete();
        nvw = 0; nout = 0; n_del = 0; n_ins = 0;
        last_drive_valid = 0; ev_prev = 0; ins_phase = 0;
        w0 = '0; w1 = '0; o0 = '0; o1 = '0;
        @(negedge wr_clk); wr_rst_n = 1'b1;
        @(negedge rd_clk); rd_rst_n = 1'b1;
    endtask

    // read-side monitor
    always @(negedge rd_clk) begin
        if (rd_rst_n && !done) begin
            if (ins_flag) begin
                chk(out_valid, "R6", "valid during repeat", out_valid, 1);
                chk({out_k, out_data} == ins_expect(ins_phase), "R6", "repeated symbol",
                    {out_k, out_data}, ins_expect(ins_phase));
                if (!ins_phase) begin
                    chk(is_pair(o1, o0), "R7", "symbols before repeat", {o1, o0}, {KCOMMA, DIDLE});
                    chk(exp_q.size() <= 10, "R5", "fill at repeat", exp_q.size(), 10);
                    n_ins++;
                end
                ins_phase = !ins_phase;
            end else begin
                chk(!ins_phase, "R6", "ins_flag length", 0, 1);
                ins_phase = 0;
                if (out_valid) begin
                    if (exp_q.size() == 0) chk(0, "R1", "unexpected output", {out_k, out_data}, 0);
                    else begin
                        logic [8:0] e;
                        e = exp_q.pop_front();
                        chk({out_k, out_data} == e, "R1", "output symbol", {out_k, out_data}, e);
                    end
                end
            end
            if (out_valid) begin
                o1 = o0; o0 = {out_k, out_data}; nout++;
            end
        end
    end

    // watchdog
    always @(posedge rd_clk) begin
        rd_cycles++;
        if (rd_cycles > WATCHDOG && !done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d expected<%0d", rd_cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic rand_stream(input int units);
        for (int u = 0; u < units; u++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 72) begin
                send(1'b1, 1'b1, 8'hBC);
                send(1'b1, 1'b0, 8'h50);
            end else if (r < 76) begin
                send(1'b1, 1'b0, 8'hBC);   // look-alike, never an idle pair
                send(1'b1, 1'b0, 8'h50);
            end else begin
                int n;
                n = $urandom_range(1, 3);
                for (int j = 0; j < n; j++) send(1'b1, 1'b0, 8'($urandom_range(0, 255)));
            end
        end
    endtask

    initial begin
        int ins_mid;
        void'($urandom(32'd2024));

        // R8 / R9: reset state and empty behaviour
        do_reset();
        @(negedge rd_clk);
        chk(!out_valid, "R8", "out_valid after reset", out_valid, 0);
        chk(!ins_flag, "R8", "ins_flag after reset", ins_flag, 0);
        chk(!del_flag, "R8", "del_flag after reset", del_flag, 0);
        idle_wr(20);
        chk(nout == 0, "R9", "outputs while empty", nout, 0);

        // R10: single symbol is held until the next one arrives
        send(1'b1, 1'b0, 8'h11);
        idle_wr(20);
        chk(nout == 0, "R10", "held symbol leaked", nout, 0);
        send(1'b1, 1'b0, 8'h22);
        idle_wr(20);
        chk(nout == 1, "R10", "held symbol released", nout, 1);

        // R5 / R6 / R7: idle pair at low fill is repeated once
        do_reset();
        send(1'b1, 1'b1, 8'hBC); send(1'b1, 1'b0, 8'h50); send(1'b1, 1'b0, 8'h11);
        idle_wr(25);
        chk(n_ins == 1, "R5", "repeat count at low fill", n_ins, 1);
        chk(nout == 4, "R6", "outputs with repeat", nout, 4);
        chk(n_del == 0, "R3", "no deletion at low fill", n_del, 0);

        // R2: look-alikes are never repeated
        do_reset();
        send(1'b1, 1'b0, 8'hBC); send(1'b1, 1'b0, 8'h50); send(1'b1, 1'b0, 8'h11);
        idle_wr(25);
        chk(n_ins == 0 && nout == 2, "R2", "0xBC data not a comma", n_ins * 16 + nout, 2);
        do_reset();
        send(1'b1, 1'b1, 8'hBC); send(1'b1, 1'b1, 8'h50); send(1'b1, 1'b0, 8'h11);
        idle_wr(25);
        chk(n_ins == 0 && nout == 2, "R2", "0x50 with K set", n_ins * 16 + nout, 2);
        do_reset();
        send(1'b1, 1'b1, 8'hBC); send(1'b1, 1'b0, 8'h33); send(1'b1, 1'b0, 8'h50);
        send(1'b1, 1'b0, 8'h11);
        idle_wr(25);
        chk(n_ins == 0 && nout == 3, "R2", "separated comma and idle", n_ins * 16 + nout, 3);

        // R3 / R5: write faster than read -> deletions, no repeats once full
        do_reset();
        wr_half = WR_FAST / 2;
        rand_stream(600);
        ins_mid = n_ins;
        rand_stream(600);
        chk(n_del > 0, "R3", "deletions with fast writer", n_del, 1);
        chk(n_ins == ins_mid, "R5", "no repeat at high fill", n_ins, ins_mid);

        // R5: write slower than read -> repeats
        ins_mid = n_ins;
        wr_half = WR_SLOW / 2;
        rand_stream(1200);
        chk(n_ins > ins_mid, "R5", "repeats with slow writer", n_ins, ins_mid + 1);

        // R1: drain, only the held last symbol may remain
        idle_wr(60);
        chk(exp_q.size() <= 1, "R1", "symbols left after drain", exp_q.size(), 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule